// File: doc/BRIEF.md
# PC Card 16-bit Socket Cycle Controller

This block runs one access at a time on a 16-bit PC Card socket. It takes a request from the host side: address, write data, direction, target space, access width and a DMA flag. It then produces the socket control strobes in three timed phases: address setup, command pulse and hold. The card enables are steered to match the access width and the width of the inserted card. The register-space select line follows the target space, the DMA flag and the socket's ATA setting. Only the one command strobe that fits the space and the direction is pulsed.

The card can stretch the command pulse by holding its wait line low. That line passes through a synchronizer, and the block looks at it only after the programmed minimum pulse width has run out. If the card holds the cycle too long, a timeout ends the access with an error. A word access to a card set up as 8 bits wide becomes two byte cycles, and the two bytes are joined into one result word. A separate gate drives the card reset line only when a card is seated, socket power is on and the interface outputs are enabled.

Top module: `pccard_cycle_ctrl`

## Requirements
- R1: On a 16-bit card, a word access asserts both card enables. A byte access asserts only CE1 (`card_ce1_n` low) when address bit 0 is 0, with the byte on data lane [7:0]. When address bit 0 is 1, it asserts only CE2 (`card_ce2_n` low), with the byte on lane [15:8]. Read bytes return in `rd_data[7:0]`.
- R2: With `cfg_8bit` high, `card_ce2_n` is never asserted. `card_addr[0]` selects the byte, and data always uses lane [7:0].
- R3: A word access (`req_wide`=1) with `cfg_8bit` high runs two complete byte cycles. The first uses address bit 0 = 0 and carries `req_wdata[7:0]`. The second uses address bit 0 = 1 and carries `req_wdata[15:8]`. Read bytes are joined as {second, first}.
- R4: On memory cycles, `card_reg_n` is low for the whole access when `req_space`=1 (attribute) and high when `req_space`=0 (common).
- R5: On I/O cycles (`req_space`=2), `card_reg_n` is low when `req_dma` is 0. It stays high when `req_dma` is 1, which acknowledges the DMA transfer to the card.
- R6: While `cfg_ata` is high, `card_reg_n` stays high on every cycle and in every space.
- R7: Command strobes are active low and assert only in the command phase, with a card enable asserted. A memory read asserts `card_oe_n`, a memory write `card_we_n`, an I/O read `card_iord_n` and an I/O write `card_iowr_n`. At most one strobe is low at any time.
- R8: Without wait, each byte or word cycle holds the enables for `cfg_setup`+1 clocks before the strobe, `cfg_pulse`+1 clocks with the strobe and `cfg_hold`+1 clocks after it. `busy` is high for exactly that span.
- R9: The wait input passes through a two-stage synchronizer and is looked at only once the minimum pulse count is reached. For `cfg_pulse`=3 and wait pulled low in the first strobe clock for W≥2 clocks, the strobe lasts W+3 clocks.
- R10: If wait is still low `TIMEOUT_CYC` clocks after the minimum pulse count is reached, the cycle ends. `rd_data` is then 16'hFFFF and `err` pulses with `done`; no second half of a split access runs.
- R11: `card_reset_oe` is high only when `card_present`, `power_on` and `if_enable` are all high. While it is high, `card_reset` (active high) equals `reset_req`.
- R12: `done` is a one-clock pulse in the first idle clock after the access. `rd_data` holds the read result, or 0 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_addr | input | ADDR_W | Card address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 0 common memory, 1 attribute memory, 2 I/O |
| req_wide | input | 1 | 1 = word access, 0 = byte access |
| req_dma | input | 1 | I/O cycle is a DMA transfer |
| cfg_ata | input | 1 | Socket in ATA mode |
| cfg_8bit | input | 1 | Socket holds an 8-bit card |
| cfg_setup | input | TIME_W | Setup clocks minus one |
| cfg_pulse | input | TIME_W | Minimum command clocks minus one |
| cfg_hold | input | TIME_W | Hold clocks minus one |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access finished (one clock) |
| rd_data | output | 16 | Read result |
| err | output | 1 | Access ended by wait timeout (with `done`) |
| card_addr | output | ADDR_W | Socket address |
| card_d_out | output | 16 | Socket write data |
| card_d_oe | output | 1 | Socket data driver enable |
| card_d_in | input | 16 | Socket read data |
| card_ce1_n | output | 1 | Even-byte card enable, active low |
| card_ce2_n | output | 1 | Odd-byte card enable, active low |
| card_reg_n | output | 1 | Register space select, active low |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_wait_n | input | 1 | Card wait request, active low, asynchronous |
| card_present | input | 1 | Card detected in the socket |
| power_on | input | 1 | Socket power applied |
| if_enable | input | 1 | Socket interface outputs enabled |
| reset_req | input | 1 | Requested card reset level |
| card_reset | output | 1 | Card reset, active high |
| card_reset_oe | output | 1 | Card reset driver enable |

## Verification
The sequencer is driven with accesses that cover:
- word and byte accesses, at even and odd addresses, on a 16-bit card;
- the same accesses on an 8-bit card;
- all three spaces, with and without the DMA flag and ATA mode.

A card model returns a distinct value for every address byte. A lane steered to the wrong byte, or two bytes joined in the wrong order, therefore yields a different read word.

The bench counts clocks with and without strobes under several timing settings. This separates setup, pulse and hold errors. A wait held for a known number of clocks tests the synchronizer latency, and a wait that is never released tests the timeout. All eight combinations of the three reset-gate conditions are applied.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   typedef enum logic [1:0] {
      SP_COMMON = 2'd0,
      SP_ATTR   = 2'd1,
      SP_IO     = 2'd2
   } space_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_CMD   = 2'd2,
      PH_HOLD  = 2'd3
   } phase_e;

   localparam int unsigned DATA_W = 16;

endpackage

// File: rtl/pcc_wait_sync.sv
module pcc_wait_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_n_async,
   output logic wait_n_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcc_wait_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   // released (high) is the safe reset value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], wait_n_async};
   end

   assign wait_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pcc_lane_steer.sv
module pcc_lane_steer #(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              active,
   input  logic              card8,
   input  logic              wide,
   input  logic              second,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output logic              ce1_n,
   output logic              ce2_n,
   output logic [ADDR_W-1:0] out_addr,
   output logic [15:0]       d_out
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("pcc_lane_steer: ADDR_W must be at least 2");
   end

   always_comb begin
      out_addr = addr;
      ce1_n    = 1'b1;
      ce2_n    = 1'b1;
      d_out    = 16'h0000;
      if (card8) begin
         // 8-bit socket: CE1 only, A0 picks the byte, low lane only
         if (wide) begin
            out_addr[0] = second;
            d_out       = {8'h00, (second ? wdata[15:8] : wdata[7:0])};
         end else begin
            d_out       = {8'h00, wdata[7:0]};
         end
         ce1_n = !active;
      end else if (wide) begin
         out_addr[0] = 1'b0;
         d_out       = wdata;
         ce1_n       = !active;
         ce2_n       = !active;
      end else if (addr[0]) begin
         d_out = {wdata[7:0], 8'h00};
         ce2_n = !active;
      end else begin
         d_out = {8'h00, wdata[7:0]};
         ce1_n = !active;
      end
      if (!active) out_addr = '0;
   end
endmodule

// File: rtl/pcc_reset_gate.sv
module pcc_reset_gate (
   input  logic card_present,
   input  logic power_on,
   input  logic if_enable,
   input  logic reset_req,
   output logic card_reset,
   output logic card_reset_oe
);
   logic safe;

   assign safe          = card_present & power_on & if_enable;
   assign card_reset_oe = safe;
   assign card_reset    = safe & reset_req;
endmodule

// File: rtl/pcc_cycle_seq.sv
module pcc_cycle_seq
   import pcc_pkg::*;
#(
   parameter int unsigned TIME_W      = 4,
   parameter int unsigned TIMEOUT_CYC = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wide,
   input  logic              card8,
   input  logic              write,
   input  logic              addr0,
   input  logic [TIME_W-1:0] cfg_setup,
   input  logic [TIME_W-1:0] cfg_pulse,
   input  logic [TIME_W-1:0] cfg_hold,
   input  logic              wait_ok,
   input  logic [15:0]       d_in,
   output phase_e            phase,
   output logic              second,
   output logic              done,
   output logic              err,
   output logic [15:0]       rd_data
);
   localparam int unsigned TMO_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
   localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYC - 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("pcc_cycle_seq: TIMEOUT_CYC must be at least 2");
   end
   if (TIME_W < 1 || TIME_W > 8) begin : g_bad_time
      $error("pcc_cycle_seq: TIME_W must be 1..8");
   end

   logic [TIME_W-1:0] cnt_q;
   logic [TMO_W-1:0]  tmo_q;
   logic              hit_q;
   logic              split;
   logic [15:0]       cap;

   assign split = card8 & wide;

   always_comb begin
      cap = rd_data;
      if (card8) begin
         if (second) cap[15:8] = d_in[7:0];
         else        cap[7:0]  = d_in[7:0];
      end else if (wide) begin
         cap = d_in;
      end else begin
         cap = {8'h00, (addr0 ? d_in[15:8] : d_in[7:0])};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt_q   <= '0;
         tmo_q   <= '0;
         hit_q   <= 1'b0;
         second  <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
         rd_data <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase   <= PH_SETUP;
                  cnt_q   <= '0;
                  second  <= 1'b0;
                  hit_q   <= 1'b0;
                  rd_data <= '0;
               end
            end
            PH_SETUP: begin
               if (cnt_q == cfg_setup) begin
                  phase <= PH_CMD;
                  cnt_q <= '0;
                  tmo_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_CMD: begin
               if (cnt_q != cfg_pulse) begin
                  cnt_q <= cnt_q + 1'b1;
               end else if (wait_ok) begin
                  if (!write) rd_data <= cap;
                  phase <= PH_HOLD;
                  cnt_q <= '0;
               end else if (tmo_q == TMO_LAST) begin
                  hit_q   <= 1'b1;
                  rd_data <= '1;
                  phase   <= PH_HOLD;
                  cnt_q   <= '0;
               end else begin
                  tmo_q <= tmo_q + 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt_q == cfg_hold) begin
                  cnt_q <= '0;
                  if (split && !second && !hit_q) begin
                     second <= 1'b1;
                     phase  <= PH_SETUP;
                  end else begin
                     phase <= PH_IDLE;
                     done  <= 1'b1;
                     err   <= hit_q;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pccard_cycle_ctrl.sv
module pccard_cycle_ctrl
   import pcc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned TIME_W      = 4,
   parameter int unsigned TIMEOUT_CYC = 1024,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   input  logic              req_write,
   input  logic [1:0]        req_space,
   input  logic              req_wide,
   input  logic              req_dma,
   input  logic              cfg_ata,
   input  logic              cfg_8bit,
   input  logic [TIME_W-1:0] cfg_setup,
   input  logic [TIME_W-1:0] cfg_pulse,
   input  logic [TIME_W-1:0] cfg_hold,
   output logic              busy,
   output logic              done,
   output logic [15:0]       rd_data,
   output logic              err,
   output logic [ADDR_W-1:0] card_addr,
   output logic [15:0]       card_d_out,
   output logic              card_d_oe,
   input  logic [15:0]       card_d_in,
   output logic              card_ce1_n,
   output logic              card_ce2_n,
   output logic              card_reg_n,
   output logic              card_oe_n,
   output logic              card_we_n,
   output logic              card_iord_n,
   output logic              card_iowr_n,
   input  logic              card_wait_n,
   input  logic              card_present,
   input  logic              power_on,
   input  logic              if_enable,
   input  logic              reset_req,
   output logic              card_reset,
   output logic              card_reset_oe
);
   phase_e            phase;
   logic              second;
   logic              wait_ok;
   logic              start;
   logic              active;
   logic              in_cmd;

   logic [ADDR_W-1:0] addr_q;
   logic [15:0]       wdata_q;
   logic              write_q;
   space_e            space_q;
   logic              wide_q;
   logic              dma_q;
   logic              ata_q;
   logic              card8_q;
   logic [TIME_W-1:0] setup_q;
   logic [TIME_W-1:0] pulse_q;
   logic [TIME_W-1:0] hold_q;

   assign start = req_valid && (phase == PH_IDLE);

   // request and socket setup are frozen for the whole access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
         space_q <= SP_COMMON;
         wide_q  <= 1'b0;
         dma_q   <= 1'b0;
         ata_q   <= 1'b0;
         card8_q <= 1'b0;
         setup_q <= '0;
         pulse_q <= '0;
         hold_q  <= '0;
      end else if (start) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         write_q <= req_write;
         space_q <= space_e'(req_space);
         wide_q  <= req_wide;
         dma_q   <= req_dma;
         ata_q   <= cfg_ata;
         card8_q <= cfg_8bit;
         setup_q <= cfg_setup;
         pulse_q <= cfg_pulse;
         hold_q  <= cfg_hold;
      end
   end

   pcc_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk          (clk),
      .rst_n        (rst_n),
      .wait_n_async (card_wait_n),
      .wait_n_sync  (wait_ok)
   );

   pcc_cycle_seq #(.TIME_W(TIME_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .wide      (wide_q),
      .card8     (card8_q),
      .write     (write_q),
      .addr0     (addr_q[0]),
      .cfg_setup (setup_q),
      .cfg_pulse (pulse_q),
      .cfg_hold  (hold_q),
      .wait_ok   (wait_ok),
      .d_in      (card_d_in),
      .phase     (phase),
      .second    (second),
      .done      (done),
      .err       (err),
      .rd_data   (rd_data)
   );

   assign active = (phase != PH_IDLE);
   assign in_cmd = (phase == PH_CMD);
   assign busy   = active;

   pcc_lane_steer #(.ADDR_W(ADDR_W)) u_steer (
      .active   (active),
      .card8    (card8_q),
      .wide     (wide_q),
      .second   (second),
      .addr     (addr_q),
      .wdata    (wdata_q),
      .ce1_n    (card_ce1_n),
      .ce2_n    (card_ce2_n),
      .out_addr (card_addr),
      .d_out    (card_d_out)
   );

   assign card_d_oe = active & write_q;

   // register-space select: attribute memory or plain I/O, never in ATA mode or on DMA I/O
   always_comb begin
      card_reg_n = 1'b1;
      if (active && !ata_q) begin
         if (space_q == SP_ATTR)              card_reg_n = 1'b0;
         else if (space_q == SP_IO && !dma_q) card_reg_n = 1'b0;
      end
   end

   logic is_io;
   assign is_io       = (space_q == SP_IO);
   assign card_oe_n   = !(in_cmd && !is_io && !write_q);
   assign card_we_n   = !(in_cmd && !is_io &&  write_q);
   assign card_iord_n = !(in_cmd &&  is_io && !write_q);
   assign card_iowr_n = !(in_cmd &&  is_io &&  write_q);

   pcc_reset_gate u_rst (
      .card_present  (card_present),
      .power_on      (power_on),
      .if_enable     (if_enable),
      .reset_req     (reset_req),
      .card_reset    (card_reset),
      .card_reset_oe (card_reset_oe)
   );
endmodule

// File: rtl/pccard_cycle_ctrl_chk.sv
module pccard_cycle_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_8bit,
   input logic        cfg_ata,
   input logic        busy,
   input logic        done,
   input logic        err,
   input logic [15:0] rd_data,
   input logic        card_ce1_n,
   input logic        card_ce2_n,
   input logic        card_reg_n,
   input logic        card_oe_n,
   input logic        card_we_n,
   input logic        card_iord_n,
   input logic        card_iowr_n,
   input logic        card_present,
   input logic        power_on,
   input logic        if_enable,
   input logic        card_reset_oe
);
   logic [3:0] strobes;
   assign strobes = {~card_oe_n, ~card_we_n, ~card_iord_n, ~card_iowr_n};

   assert_ce2_off_8bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_8bit |-> card_ce2_n);

   assert_reg_off_ata_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ata |-> card_reg_n);

   assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobes));

   assert_strobe_in_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes != 4'b0000) |-> (busy && (!card_ce1_n || !card_ce2_n)));

   assert_timeout_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && rd_data == 16'hFFFF));

   assert_reset_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      card_reset_oe |-> (card_present && power_on && if_enable));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind pccard_cycle_ctrl pccard_cycle_ctrl_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_8bit      (cfg_8bit),
   .cfg_ata       (cfg_ata),
   .busy          (busy),
   .done          (done),
   .err           (err),
   .rd_data       (rd_data),
   .card_ce1_n    (card_ce1_n),
   .card_ce2_n    (card_ce2_n),
   .card_reg_n    (card_reg_n),
   .card_oe_n     (card_oe_n),
   .card_we_n     (card_we_n),
   .card_iord_n   (card_iord_n),
   .card_iowr_n   (card_iowr_n),
   .card_present  (card_present),
   .power_on      (power_on),
   .if_enable     (if_enable),
   .card_reset_oe (card_reset_oe)
);

// File: tb/pccard_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module pccard_cycle_ctrl_tb_top;
   localparam int AW  = 12;
   localparam int TW  = 4;
   localparam int TMO = 8;

   typedef struct {
      string       tag;
      logic [15:0] rd;
      logic        err;
      logic        ce1;
      logic        ce2;
      logic        reg_lo;
      int          kind;   // 0 OE, 1 WE, 2 IORD, 3 IOWR
      int          pulses;
      int          act;
      int          strb;
      logic        chk_d;
      logic [15:0] d0;
      logic [15:0] d1;
      logic        a00;
      logic        a01;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   req_wdata = '0;
   logic          req_write = 1'b0;
   logic [1:0]    req_space = 2'd0;
   logic          req_wide = 1'b0;
   logic          req_dma = 1'b0;
   logic          cfg_ata = 1'b0;
   logic          cfg_8bit = 1'b0;
   logic [TW-1:0] cfg_setup = 4'd1;
   logic [TW-1:0] cfg_pulse = 4'd2;
   logic [TW-1:0] cfg_hold = 4'd1;
   logic          busy, done, err, card_d_oe;
   logic [15:0]   rd_data, card_d_out;
   logic [15:0]   card_d_in;
   logic [AW-1:0] card_addr;
   logic          card_ce1_n, card_ce2_n, card_reg_n;
   logic          card_oe_n, card_we_n, card_iord_n, card_iowr_n;
   logic          card_wait_n = 1'b1;
   logic          card_present = 1'b0;
   logic          power_on = 1'b0;
   logic          if_enable = 1'b0;
   logic          reset_req = 1'b0;
   logic          card_reset, card_reset_oe;

   int checks = 0;
   int errors = 0;
   int completed = 0;
   bit finished = 0;
   exp_t q[$];

   always #2 clk = ~clk;

   pccard_cycle_ctrl #(.ADDR_W(AW), .TIME_W(TW), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .req_space(req_space),
      .req_wide(req_wide), .req_dma(req_dma), .cfg_ata(cfg_ata), .cfg_8bit(cfg_8bit),
      .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
      .busy(busy), .done(done), .rd_data(rd_data), .err(err),
      .card_addr(card_addr), .card_d_out(card_d_out), .card_d_oe(card_d_oe),
      .card_d_in(card_d_in), .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n),
      .card_reg_n(card_reg_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
      .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n), .card_wait_n(card_wait_n),
      .card_present(card_present), .power_on(power_on), .if_enable(if_enable),
      .reset_req(reset_req), .card_reset(card_reset), .card_reset_oe(card_reset_oe)
   );

   // card model: each address byte holds a distinct value
   function automatic logic [7:0] bat(input logic [AW-1:0] a);
      return a[7:0] ^ 8'h3C ^ {4'h0, a[11:8]};
   endfunction

   always_comb begin
      if (cfg_8bit) card_d_in = {8'hEE, bat(card_addr)};
      else          card_d_in = {bat(card_addr | 12'h001), bat(card_addr & ~12'h001)};
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // wait responder: 0 released, 1 pulse of wait_w clocks at first strobe clock, 2 stuck low
   int wait_mode = 0;
   int wait_w = 0;
   int wait_left = 0;
   bit wait_fired = 0;
   logic strb_now;
   assign strb_now = !card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n;

   initial forever begin
      @(negedge clk);
      if (wait_mode == 2) card_wait_n = 1'b0;
      else if (wait_mode == 1) begin
         if (!wait_fired && strb_now) begin
            card_wait_n = 1'b0; wait_left = wait_w; wait_fired = 1;
         end else if (wait_left > 0) begin
            wait_left--;
            if (wait_left == 0) card_wait_n = 1'b1;
         end
      end else card_wait_n = 1'b1;
   end

   // monitor: gathers per-access observations and compares at done
   int act_c = 0, ce1_c = 0, ce2_c = 0, reg_c = 0, strb_c = 0, pulses_c = 0;
   int kc[4] = '{0, 0, 0, 0};
   logic [15:0] d0_o = '0, d1_o = '0;
   logic a00_o = 1'b0, a01_o = 1'b0;
   bit prev_strb = 0;
   bit prev_done = 0;

   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         if (prev_done) chk(done == 1'b0, "R12", "done width", done, 0);
         prev_done = 0;
         if (busy) act_c++;
         if (!card_ce1_n) ce1_c++;
         if (!card_ce2_n) ce2_c++;
         if (busy && !card_reg_n) reg_c++;
         if (!card_oe_n) kc[0]++;
         if (!card_we_n) kc[1]++;
         if (!card_iord_n) kc[2]++;
         if (!card_iowr_n) kc[3]++;
         if (strb_now) strb_c++;
         if (strb_now && !prev_strb) begin
            pulses_c++;
            if (pulses_c == 1) begin d0_o = card_d_out; a00_o = card_addr[0]; end
            d1_o = card_d_out; a01_o = card_addr[0];
         end
         prev_strb = strb_now;
         if (done) begin
            if (q.size() == 0) chk(0, "R12", "unexpected done", 1, 0);
            else begin
               exp_t e;
               e = q.pop_front();
               chk(rd_data == e.rd, e.tag, "rd_data", rd_data, e.rd);
               chk(err == e.err, "R10", "err", err, e.err);
               chk((ce1_c > 0) == e.ce1, e.tag, "ce1 used", ce1_c > 0, e.ce1);
               chk((ce2_c > 0) == e.ce2, e.tag, "ce2 used", ce2_c > 0, e.ce2);
               chk(reg_c == (e.reg_lo ? act_c : 0), e.tag, "reg low clocks",
                   reg_c, e.reg_lo ? act_c : 0);
               chk(kc[e.kind] == strb_c && strb_c > 0, "R7", "strobe kind clocks",
                   kc[e.kind], strb_c);
               chk(pulses_c == e.pulses, e.tag, "pulses", pulses_c, e.pulses);
               if (e.act >= 0) chk(act_c == e.act, "R8", "busy clocks", act_c, e.act);
               if (e.strb >= 0) chk(strb_c == e.strb, "R8", "strobe clocks", strb_c, e.strb);
               chk(a00_o == e.a00, e.tag, "first A0", a00_o, e.a00);
               chk(a01_o == e.a01, e.tag, "last A0", a01_o, e.a01);
               if (e.chk_d) begin
                  chk(d0_o == e.d0, e.tag, "first write lanes", d0_o, e.d0);
                  chk(d1_o == e.d1, e.tag, "last write lanes", d1_o, e.d1);
               end
            end
            completed++;
            prev_done = 1;
            act_c = 0; ce1_c = 0; ce2_c = 0; reg_c = 0; strb_c = 0; pulses_c = 0;
            kc = '{0, 0, 0, 0};
         end
      end
   end

   function automatic exp_t mk(input string tag, input logic [15:0] rd, input logic er,
                               input logic c1, input logic c2, input logic rl, input int kind,
                               input int pulses, input int act, input int strb,
                               input logic cd, input logic [15:0] d0, input logic [15:0] d1,
                               input logic a00, input logic a01);
      exp_t e;
      e.tag = tag; e.rd = rd; e.err = er; e.ce1 = c1; e.ce2 = c2; e.reg_lo = rl;
      e.kind = kind; e.pulses = pulses; e.act = act; e.strb = strb; e.chk_d = cd;
      e.d0 = d0; e.d1 = d1; e.a00 = a00; e.a01 = a01;
      return e;
   endfunction

   task automatic run(input logic [AW-1:0] a, input logic [15:0] wd, input logic wr,
                      input logic [1:0] sp, input logic wide, input logic dma, input exp_t e);
      int target;
      target = completed + 1;
      q.push_back(e);
      wait_fired = 0;
      @(negedge clk);
      req_addr = a; req_wdata = wd; req_write = wr; req_space = sp;
      req_wide = wide; req_dma = dma; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (completed < target) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "R12", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk(card_ce1_n && card_ce2_n && card_reg_n, "R7", "reset enables", 0, 1);
      chk(card_oe_n && card_we_n && card_iord_n && card_iowr_n, "R7", "reset strobes", 0, 1);
      chk(!busy && !done, "R12", "reset busy/done", {busy, done}, 0);
      chk(!card_reset_oe, "R11", "reset gate at reset", card_reset_oe, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 word read, common memory (R4 common keeps reg high): S1 P2 H1 -> 7 busy, 3 strobe
      run(12'h120, 16'h0, 0, 2'd0, 1, 0,
          mk("R1", {bat(12'h121), bat(12'h120)}, 0, 1, 1, 0, 0, 1, 7, 3, 0, 0, 0, 0, 0));
      // R4 attribute byte read at odd address: CE2 only, upper lane
      run(12'h201, 16'h0, 0, 2'd1, 0, 0,
          mk("R4", {8'h00, bat(12'h201)}, 0, 0, 1, 1, 0, 1, 7, 3, 0, 0, 0, 1, 1));
      // R1 word write, common memory
      run(12'h042, 16'hBEEF, 1, 2'd0, 1, 0,
          mk("R1", 16'h0000, 0, 1, 1, 0, 1, 1, 7, 3, 1, 16'hBEEF, 16'hBEEF, 0, 0));
      // R1 byte write at even address, attribute: CE1 only, low lane
      run(12'h0A4, 16'h775A, 1, 2'd1, 0, 0,
          mk("R1", 16'h0000, 0, 1, 0, 1, 1, 1, 7, 3, 1, 16'h005A, 16'h005A, 0, 0));
      // R1 byte write at odd address: CE2, data on upper lane
      run(12'h0A5, 16'h11C3, 1, 2'd0, 0, 0,
          mk("R1", 16'h0000, 0, 0, 1, 0, 1, 1, 7, 3, 1, 16'hC300, 16'hC300, 1, 1));
      // R5 plain I/O word read: IORD, reg low
      run(12'h3F0, 16'h0, 0, 2'd2, 1, 0,
          mk("R5", {bat(12'h3F1), bat(12'h3F0)}, 0, 1, 1, 1, 2, 1, 7, 3, 0, 0, 0, 0, 0));
      // R5 DMA I/O write: IOWR, reg high
      run(12'h3F2, 16'h2468, 1, 2'd2, 1, 1,
          mk("R5", 16'h0000, 0, 1, 1, 0, 3, 1, 7, 3, 1, 16'h2468, 16'h2468, 0, 0));
      // R6 ATA mode: attribute read and plain I/O read keep reg high
      cfg_ata = 1'b1;
      run(12'h010, 16'h0, 0, 2'd1, 1, 0,
          mk("R6", {bat(12'h011), bat(12'h010)}, 0, 1, 1, 0, 0, 1, 7, 3, 0, 0, 0, 0, 0));
      run(12'h1F7, 16'h0, 0, 2'd2, 0, 0,
          mk("R6", {8'h00, bat(12'h1F7)}, 0, 0, 1, 0, 2, 1, 7, 3, 0, 0, 0, 1, 1));
      cfg_ata = 1'b0;
      // R3 8-bit card word read: two byte cycles, even first, joined
      cfg_8bit = 1'b1;
      run(12'h300, 16'h0, 0, 2'd0, 1, 0,
          mk("R3", {bat(12'h301), bat(12'h300)}, 0, 1, 0, 0, 0, 2, 14, 6, 0, 0, 0, 0, 1));
      // R3 8-bit card word write: low byte first on low lane
      run(12'h302, 16'h1234, 1, 2'd1, 1, 0,
          mk("R3", 16'h0000, 0, 1, 0, 1, 1, 2, 14, 6, 1, 16'h0034, 16'h0012, 0, 1));
      // R2 8-bit card byte read at odd address: CE1 only, A0 high, low lane
      run(12'h305, 16'h0, 0, 2'd2, 0, 0,
          mk("R2", {8'h00, bat(12'h305)}, 0, 1, 0, 1, 2, 1, 7, 3, 0, 0, 0, 1, 1));
      cfg_8bit = 1'b0;
      // R8 minimum timing S0 P0 H0 and longer S3 P5 H2
      cfg_setup = 4'd0; cfg_pulse = 4'd0; cfg_hold = 4'd0;
      run(12'h088, 16'h0, 0, 2'd0, 1, 0,
          mk("R8", {bat(12'h089), bat(12'h088)}, 0, 1, 1, 0, 0, 1, 3, 1, 0, 0, 0, 0, 0));
      cfg_setup = 4'd3; cfg_pulse = 4'd5; cfg_hold = 4'd2;
      run(12'h08A, 16'h5A5A, 1, 2'd2, 1, 0,
          mk("R8", 16'h0000, 0, 1, 1, 1, 3, 1, 13, 6, 1, 16'h5A5A, 16'h5A5A, 0, 0));
      // R9 wait held 6 clocks with P3: strobe lasts 9 clocks
      cfg_setup = 4'd1; cfg_pulse = 4'd3; cfg_hold = 4'd1;
      wait_mode = 1; wait_w = 6;
      run(12'h0C0, 16'h0, 0, 2'd0, 1, 0,
          mk("R9", {bat(12'h0C1), bat(12'h0C0)}, 0, 1, 1, 0, 0, 1, 13, 9, 0, 0, 0, 0, 0));
      wait_mode = 0;
      repeat (4) @(negedge clk);
      // R10 stuck wait on an 8-bit split read: ends after one byte, all ones, err
      cfg_pulse = 4'd1; cfg_8bit = 1'b1;
      wait_mode = 2;
      repeat (4) @(negedge clk);
      run(12'h0E0, 16'h0, 0, 2'd0, 1, 0,
          mk("R10", 16'hFFFF, 1, 1, 0, 0, 0, 1, 2 + 1 + TMO + 2, 1 + TMO, 0, 0, 0, 0, 0));
      wait_mode = 0; cfg_8bit = 1'b0;
      repeat (4) @(negedge clk);
      // R11 reset gate over all condition combinations
      for (int i = 0; i < 8; i++) begin
         card_present = i[0]; power_on = i[1]; if_enable = i[2]; reset_req = 1'b1;
         @(negedge clk);
         chk(card_reset_oe == (i == 7), "R11", "reset drive enable", card_reset_oe, i == 7);
         if (i == 7) chk(card_reset == 1'b1, "R11", "reset level", card_reset, 1);
      end
      reset_req = 1'b0;
      @(negedge clk);
      chk(card_reset == 1'b0 && card_reset_oe, "R11", "reset released", card_reset, 0);
      chk(q.size() == 0, "R12", "pending results", q.size(), 0);
      finish_run();
   end
endmodule